// File: doc/BRIEF.md
# Host Command Mailbox

This block is a small shared command buffer between a host and a processing engine. It holds five 32-bit words: a command word at word address 0 and four parameter words at word addresses 1 to 4. The host fills the parameter words first and writes the command word last. A command byte with its top bit set marks a valid command. The block then holds the command as busy, sends the engine a one-cycle start pulse, and presents all four parameters on a wide bus.

When the engine finishes, it raises a done strobe together with a return code. The block clears the command byte to zero, which frees the buffer. It stores the return code in the command word, where the host reads it. The host polls for a free buffer before it writes, and reads results through a one-cycle-latency read port.

Host writes use a valid/ready channel. Ready is the only source of back-pressure. Ready drops in any cycle in which the engine asserts done, so a completion never collides with a host write. The host must hold its valid, address and data until it sees ready high at a clock edge. The read port and the engine signals are plain control pins.

Top module: `host_cmd_mailbox`

## Requirements
- R1: After reset every word reads as zero, `buf_free` is 1, and `cmd_busy`, `err_busy_wr` and `eng_cmd_pulse` are 0.
- R2: A read request returns its data with `host_rd_valid` one cycle later. Word address 0 returns the command word, addresses 1 to 4 return the parameter words, and any higher address returns zero.
- R3: An accepted write to word 0 with bit 7 set, while the engine is enabled and the buffer is not busy, stores the word. `cmd_busy` then goes high, and `eng_cmd_pulse` is high for exactly the one cycle after the write handshake. `eng_cmd_byte` shows bits 7:0 of the word.
- R4: An accepted write to word 0 with bit 7 clear is stored without raising `cmd_busy` or the pulse. `buf_free` is 1 exactly when bits 7:0 of word 0 are zero.
- R5: A write to word 0 while `eng_enable` is low is dropped. The stored word, `cmd_busy` and the pulse are unchanged.
- R6: While `cmd_busy` is high, a write to any word address 0 to 4 is dropped and sets `err_busy_wr`. The flag stays set until reset.
- R7: `eng_done` while busy clears bits 7:0 of word 0 and loads `eng_rc` into bits 15:8. Bits 31:16 are left unchanged. In the next cycle `buf_free` is 1 and `cmd_busy` is 0.
- R8: `eng_done` while not busy has no effect on any word.
- R9: `host_wr_ready` is low in every cycle in which `eng_done` is high, and no host write takes effect in that cycle.
- R10: `eng_params` carries parameter word 1 in bits 31:0 up to word 4 in bits 127:96.
- R11: Writes to word addresses 5 to 7 are dropped and do not set `err_busy_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_valid | input | 1 | Host write request |
| host_wr_ready | output | 1 | Host write accepted at this edge when high |
| host_wr_addr | input | 3 | Word address of the write |
| host_wr_data | input | 32 | Write data |
| host_rd_en | input | 1 | Host read request |
| host_rd_addr | input | 3 | Word address of the read |
| host_rd_valid | output | 1 | Read data valid, one cycle after the request |
| host_rd_data | output | 32 | Read data |
| buf_free | output | 1 | Command byte is zero |
| cmd_busy | output | 1 | A command is pending (bit 7 of the command byte) |
| err_busy_wr | output | 1 | Sticky flag: a write arrived while busy |
| eng_enable | input | 1 | Engine accepts commands |
| eng_cmd_pulse | output | 1 | One-cycle start strobe to the engine |
| eng_cmd_byte | output | 8 | Current command byte |
| eng_params | output | 128 | Four parameter words, word 1 lowest |
| eng_done | input | 1 | Engine completion strobe |
| eng_rc | input | 8 | Return code captured on completion |

## Verification
A corrupted command byte shows on `cmd_busy`, `buf_free` and `eng_cmd_byte` in the cycle after the bad edge. It also shows in the next read of word 0. A parameter register that was overwritten while busy changes `eng_params` at once, and the readback shows the change one cycle later. A lost or stretched start strobe can be seen only in the cycle right after the write handshake, so the bench samples the pulse in that cycle and in the one after it. A missed return-code capture appears in word 0 bits 15:8 on the first read after done.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_CMD    = 2'd1,
    WK_PARAM  = 2'd2,
    WK_REJECT = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/mbx_wr_decode.sv
module mbx_wr_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int N_WORDS = 5
) (
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic              enable,
  output wr_kind_e          kind
);
  logic in_range;
  assign in_range = 32'(addr) < 32'(N_WORDS);

  always_comb begin
    kind = WK_NONE;
    if (fire && in_range) begin
      if (busy)              kind = WK_REJECT;
      else if (addr == '0)   kind = enable ? WK_CMD : WK_NONE;
      else                   kind = WK_PARAM;
    end
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_PARAM = 4,
  parameter int ADDR_W  = 3,
  parameter int CMD_W   = 8,
  parameter int RC_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  wr_kind_e                  kind,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         data,
  input  logic                      done_take,
  input  logic [RC_W-1:0]           rc,
  output logic [DATA_W-1:0]         cmd_word,
  output logic [N_PARAM*DATA_W-1:0] params
);
  localparam int RC_LSB = CMD_W;

  logic [DATA_W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (done_take) begin
      cmd_q[CMD_W-1:0]       <= '0;
      cmd_q[RC_LSB +: RC_W]  <= rc;
    end else if (kind == WK_CMD) begin
      cmd_q <= data;
    end
  end
  assign cmd_word = cmd_q;

  for (genvar i = 0; i < N_PARAM; i++) begin : g_par
    logic [DATA_W-1:0] par_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        par_q <= '0;
      else if (kind == WK_PARAM && addr == ADDR_W'(i + 1))
        par_q <= data;
    end
    assign params[i*DATA_W +: DATA_W] = par_q;
  end
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_kind_e         kind,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             pulse,
  output logic             err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      err   <= 1'b0;
    end else begin
      pulse <= (kind == WK_CMD) && cmd_in[CMD_W-1];
      err   <= err | (kind == WK_REJECT);
    end
  end
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
  parameter int DATA_W  = 32,
  parameter int N_PARAM = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [DATA_W-1:0]         cmd_word,
  input  logic [N_PARAM*DATA_W-1:0] params,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int N_WORDS = N_PARAM + 1;

  logic [DATA_W-1:0] words [N_WORDS];
  logic [DATA_W-1:0] sel;

  assign words[0] = cmd_word;
  for (genvar i = 0; i < N_PARAM; i++) begin : g_map
    assign words[i+1] = params[i*DATA_W +: DATA_W];
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < N_WORDS; k++)
      if (rd_addr == ADDR_W'(k)) sel = words[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/host_cmd_mailbox.sv
module host_cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_PARAM = 4,
  parameter int CMD_W   = 8,
  parameter int RC_W    = 8,
  parameter int ADDR_W  = $clog2(N_PARAM + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_wr_valid,
  output logic                      host_wr_ready,
  input  logic [ADDR_W-1:0]         host_wr_addr,
  input  logic [DATA_W-1:0]         host_wr_data,
  input  logic                      host_rd_en,
  input  logic [ADDR_W-1:0]         host_rd_addr,
  output logic                      host_rd_valid,
  output logic [DATA_W-1:0]         host_rd_data,
  output logic                      buf_free,
  output logic                      cmd_busy,
  output logic                      err_busy_wr,
  input  logic                      eng_enable,
  output logic                      eng_cmd_pulse,
  output logic [CMD_W-1:0]          eng_cmd_byte,
  output logic [N_PARAM*DATA_W-1:0] eng_params,
  input  logic                      eng_done,
  input  logic [RC_W-1:0]           eng_rc
);
  localparam int N_WORDS = N_PARAM + 1;

  wr_kind_e          kind;
  logic              fire;
  logic              done_take;
  logic [DATA_W-1:0] cmd_word;

  assign host_wr_ready = !eng_done;
  assign fire          = host_wr_valid && host_wr_ready;
  assign eng_cmd_byte  = cmd_word[CMD_W-1:0];
  assign cmd_busy      = cmd_word[CMD_W-1];
  assign buf_free      = (cmd_word[CMD_W-1:0] == '0);
  assign done_take     = eng_done && cmd_busy;

  mbx_wr_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_dec (
    .fire(fire), .addr(host_wr_addr), .busy(cmd_busy),
    .enable(eng_enable), .kind(kind)
  );

  mbx_store #(.DATA_W(DATA_W), .N_PARAM(N_PARAM), .ADDR_W(ADDR_W),
              .CMD_W(CMD_W), .RC_W(RC_W)) u_store (
    .clk(clk), .rst_n(rst_n), .kind(kind), .addr(host_wr_addr),
    .data(host_wr_data), .done_take(done_take), .rc(eng_rc),
    .cmd_word(cmd_word), .params(eng_params)
  );

  mbx_status #(.CMD_W(CMD_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .kind(kind),
    .cmd_in(host_wr_data[CMD_W-1:0]),
    .pulse(eng_cmd_pulse), .err(err_busy_wr)
  );

  mbx_rd_port #(.DATA_W(DATA_W), .N_PARAM(N_PARAM), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(host_rd_en), .rd_addr(host_rd_addr),
    .cmd_word(cmd_word), .params(eng_params),
    .rd_valid(host_rd_valid), .rd_data(host_rd_data)
  );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DATA_W  = 32,
  parameter int N_PARAM = 4,
  parameter int CMD_W   = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      host_wr_valid,
  input logic                      host_rd_en,
  input logic                      host_rd_valid,
  input logic                      buf_free,
  input logic                      cmd_busy,
  input logic                      err_busy_wr,
  input logic                      eng_enable,
  input logic                      eng_cmd_pulse,
  input logic [CMD_W-1:0]          eng_cmd_byte,
  input logic [N_PARAM*DATA_W-1:0] eng_params,
  input logic                      eng_done
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rd_valid); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_pulse |=> !eng_cmd_pulse); // R3
  AST_PULSE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_pulse |-> cmd_busy); // R3
  AST_NO_CMD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_enable |=> !$rose(cmd_busy)); // R5
  AST_PARAMS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |=> $stable(eng_params)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy_wr |=> err_busy_wr); // R6
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && cmd_busy) |=> (buf_free && !cmd_busy)); // R7
  AST_DONE_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !cmd_busy) |=> $stable(eng_cmd_byte)); // R8
  AST_STALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && host_wr_valid && !cmd_busy) |=> $stable(eng_params)); // R9
endmodule

bind host_cmd_mailbox mbx_checker #(.DATA_W(DATA_W), .N_PARAM(N_PARAM), .CMD_W(CMD_W)) u_chk (.*);

// File: tb/sim_host_cmd_mailbox.sv
module sim_host_cmd_mailbox;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [2:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [2:0]   rd_addr = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         free_o, busy_o, err_o, pulse_o;
  logic         en = 1'b0;
  logic [7:0]   cmd_byte;
  logic [127:0] params;
  logic         done = 1'b0;
  logic [7:0]   rc = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_w [5];
  logic        exp_err;

  always #2 clk = ~clk;

  host_cmd_mailbox u0 (
    .clk(clk), .rst_n(rst_n),
    .host_wr_valid(wr_valid), .host_wr_ready(wr_ready),
    .host_wr_addr(wr_addr), .host_wr_data(wr_data),
    .host_rd_en(rd_en), .host_rd_addr(rd_addr),
    .host_rd_valid(rd_valid), .host_rd_data(rd_data),
    .buf_free(free_o), .cmd_busy(busy_o), .err_busy_wr(err_o),
    .eng_enable(en), .eng_cmd_pulse(pulse_o), .eng_cmd_byte(cmd_byte),
    .eng_params(params), .eng_done(done), .eng_rc(rc)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a[2:0];
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data; v = rd_valid;
  endtask

  task automatic check_state(input string r);
    logic [31:0] d;
    logic v;
    chk(r, {31'd0, busy_o}, {31'd0, exp_w[0][7]});
    chk(r, {31'd0, free_o}, {31'd0, exp_w[0][7:0] == 8'd0});
    chk(r, {24'd0, cmd_byte}, {24'd0, exp_w[0][7:0]});
    chk("R6 err flag", {31'd0, err_o}, {31'd0, exp_err});
    for (int i = 0; i < 4; i++)
      chk("R10 param bus", params[i*32 +: 32], exp_w[i+1]);
    for (int a = 0; a < 8; a++) begin
      rd(a, d, v);
      chk("R2 rd valid", {31'd0, v}, 32'd1);
      chk(a > 4 ? "R11 high addr read" : "R2 readback", d, a > 4 ? 32'd0 : exp_w[a]);
    end
  endtask

  task automatic hw(input string r, input int a, input logic [31:0] d);
    logic exp_pulse;
    exp_pulse = 1'b0;
    if (a < 5) begin
      if (exp_w[0][7]) exp_err = 1'b1;
      else if (a == 0) begin
        if (en) begin exp_w[0] = d; exp_pulse = d[7]; end
      end else exp_w[a] = d;
    end
    @(negedge clk); wr_valid = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_valid = 1'b0;
    chk("R3 pulse", {31'd0, pulse_o}, {31'd0, exp_pulse});
    @(negedge clk);
    chk("R3 pulse width", {31'd0, pulse_o}, 32'd0);
    check_state(r);
  endtask

  task automatic eng_finish(input logic [7:0] code);
    string r;
    r = exp_w[0][7] ? "R7" : "R8";
    if (exp_w[0][7]) begin
      exp_w[0][7:0] = 8'd0;
      exp_w[0][15:8] = code;
    end
    @(negedge clk);
    done = 1'b1; rc = code;
    wr_valid = 1'b1; wr_addr = 3'd1; wr_data = 32'hDEAD_0000 ^ {24'd0, code};
    #1 chk("R9 ready low", {31'd0, wr_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk); done = 1'b0; wr_valid = 1'b0;
    check_state(r);
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 5; i++) exp_w[i] = '0;
    exp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse", {31'd0, pulse_o}, 32'd0);
    chk("R1 free", {31'd0, free_o}, 32'd1);
    check_state("R1");
    for (int e = 0; e < 2; e++) begin
      en = e[0];
      for (int a = 0; a < 8; a++) begin
        for (int p = 0; p < 4; p++) begin
          d = (32'h9E37_79B9 * 32'(a * 4 + p + 1)) ^ {16'h0, 8'(e), 8'h00};
          d[7] = p[0];
          if (p == 2) d[7:0] = 8'd0;
          if (a == 0) hw(!en ? "R5" : (d[7] ? "R3" : "R4"), a, d);
          else hw(a > 4 ? "R11" : "R2", a, d);
          if (exp_w[0][7]) hw("R6", 1 + p, ~d);
          eng_finish(8'(a * 16 + p + 1));
        end
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule